// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to an 8-bit processor core. It enters interrupt service routines and the reset routine. It watches three request sources: a level-sensitive maskable interrupt line, an edge-sensitive non-maskable interrupt line, and a reset request. When the core raises its instruction-boundary strobe, the block decides whether one of these events must be serviced. If one must, it takes over the byte-wide memory port. It pushes the return address and the status byte onto the page-one stack and then fetches the new program counter from the vector pair that belongs to the event.

The core presents its live program counter, stack pointer and status byte. When a sequence finishes, the block returns the updated values on its outputs together with a one-cycle completion strobe. The core can also signal that it has halted on an illegal opcode. From then on, interrupts are refused until a reset sequence clears the halted state. A reset request does not wait for a boundary: it is taken as soon as the block is idle.

Top module: `irq_entry_seq`

## Requirements
- R1: After the asynchronous reset is released, `busy_o`, `done_o`, `mem_we_o`, `mem_re_o` and `jammed_o` are 0, and `pc_o`, `sp_o` and `status_o` are 0.
- R2: If a non-maskable request is pending and the maskable line is also active at a boundary, the non-maskable entry runs, fetching its vector from 0xFFFA (low byte) and 0xFFFB (high byte).
- R3: A maskable request is refused when the interrupt-disable flag (status bit 2) is 1. The flag value tested is the one captured at the previous boundary, or the one produced by the last completed entry, whichever is more recent. It is not the value presented at the current boundary.
- R4: An interrupt entry writes three bytes in this order: PC high, PC low, status. Each write goes to address 0x0100 + SP, and SP then decrements modulo 256. `sp_o` returns SP minus 3.
- R5: The pushed status equals the input status with bit 4 cleared and bit 5 set. The returned status also has bit 4 cleared.
- R6: The maskable entry reads its vector from 0xFFFE/0xFFFF, low byte first, and sets status bit 2 in `status_o`. The non-maskable entry leaves bit 2 as it was.
- R7: `busy_o` is high for exactly 7 clock cycles per interrupt entry, starting the cycle after the boundary. `done_o` pulses for one cycle right after, with the new `pc_o`, `sp_o` and `status_o` valid in that cycle.
- R8: A reset request loads `pc_o` from 0xFFFC/0xFFFD, sets `status_o` to 0x04, passes SP through, clears `jammed_o`, keeps `busy_o` high for 2 cycles, and writes no memory.
- R9: While `jammed_o` is 1, a boundary starts no interrupt entry, and a pending non-maskable request is discarded at that boundary.
- R10: A non-maskable request is latched on a rising edge only; holding the line high does not request it again. The maskable line is re-sampled at every boundary, so a dropped line requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is between instructions this cycle |
| irq_req_i | input | 1 | Maskable interrupt request, level |
| nmi_req_i | input | 1 | Non-maskable interrupt request, rising edge |
| rst_req_i | input | 1 | Request to run the reset entry |
| jam_i | input | 1 | Core has halted; refuse interrupts |
| pc_i | input | 16 | Live program counter |
| sp_i | input | 8 | Live stack pointer |
| status_i | input | 8 | Live status byte |
| mem_rdata_i | input | 8 | Read data, combinational from mem_addr_o |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Program counter after the sequence |
| sp_o | output | 8 | Stack pointer after the sequence |
| status_o | output | 8 | Status after the sequence |
| jammed_o | output | 1 | Halted state |

## Verification
The hardest case to reach is the one-boundary lag of the mask flag. The core sets the disable flag in an instruction, yet a maskable request at the very next boundary must still be taken. The stimulus reaches it by first presenting a boundary with the flag clear and no request, and then a boundary with the flag set and the line active. It also runs the opposite order, where a request must be refused even though the flag has just been cleared. A second hard case is a non-maskable edge that arrives while the core is halted: it must be lost, not held until after the reset clears the halt.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned FLG_I = 2;
  localparam int unsigned FLG_B = 4;
  localparam int unsigned FLG_U = 5;

  typedef enum logic [1:0] {
    K_NMI = 2'd0,
    K_IRQ = 2'd1,
    K_RST = 2'd2
  } evt_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FILL0 = 3'd1,
    S_FILL1 = 3'd2,
    S_PSH_H = 3'd3,
    S_PSH_L = 3'd4,
    S_PSH_P = 3'd5,
    S_VEC_L = 3'd6,
    S_VEC_H = 3'd7
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] vec_base(evt_kind_e k);
    logic [ADDR_W-1:0] a;
    case (k)
      K_NMI:   a = 16'hFFFA;
      K_IRQ:   a = 16'hFFFE;
      default: a = 16'hFFFC;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/irq_evt_arbiter.sv
module irq_evt_arbiter
  import irq_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boundary_i,
  input  logic      idle_i,
  input  logic      irq_i,
  input  logic      nmi_i,
  input  logic      rst_req_i,
  input  logic      jam_i,
  input  logic      iflag_now_i,
  input  logic      done_i,
  input  logic      done_iflag_i,
  output logic      start_o,
  output evt_kind_e kind_o,
  output logic      jammed_o
);
  logic nmi_prev_q, nmi_pend_q, rst_pend_q, jammed_q, iflag_lat_q;
  logic nmi_pend_d, rst_pend_d, jammed_d, iflag_lat_d;
  logic nmi_rise, take_rst, check, take_nmi, take_irq;

  always_comb begin
    nmi_rise = nmi_i & ~nmi_prev_q;
    take_rst = idle_i & (rst_pend_q | rst_req_i);
    check    = idle_i & boundary_i & ~take_rst;
    take_nmi = check & ~jammed_q & nmi_pend_q;
    take_irq = check & ~jammed_q & ~nmi_pend_q & irq_i & ~iflag_lat_q;

    start_o = take_rst | take_nmi | take_irq;
    if (take_rst)      kind_o = K_RST;
    else if (take_nmi) kind_o = K_NMI;
    else               kind_o = K_IRQ;

    if (nmi_rise)   nmi_pend_d = 1'b1;
    else if (check) nmi_pend_d = 1'b0;
    else            nmi_pend_d = nmi_pend_q;

    if (take_rst)       rst_pend_d = 1'b0;
    else if (rst_req_i) rst_pend_d = 1'b1;
    else                rst_pend_d = rst_pend_q;

    if (take_rst)   jammed_d = 1'b0;
    else if (jam_i) jammed_d = 1'b1;
    else            jammed_d = jammed_q;

    if (done_i)                               iflag_lat_d = done_iflag_i;
    else if (check && !(take_nmi || take_irq)) iflag_lat_d = iflag_now_i;
    else                                      iflag_lat_d = iflag_lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q  <= 1'b0;
      nmi_pend_q  <= 1'b0;
      rst_pend_q  <= 1'b0;
      jammed_q    <= 1'b0;
      iflag_lat_q <= 1'b1;
    end else begin
      nmi_prev_q  <= nmi_i;
      nmi_pend_q  <= nmi_pend_d;
      rst_pend_q  <= rst_pend_d;
      jammed_q    <= jammed_d;
      iflag_lat_q <= iflag_lat_d;
    end
  end

  assign jammed_o = jammed_q;

  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && nmi_pend_q && kind_o != K_RST) |-> kind_o == K_NMI);
  assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && kind_o == K_IRQ) |-> !iflag_lat_q);
  assert_jam_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jammed_q |-> !(start_o && kind_o != K_RST));
  assert_nmi_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend_q) |-> ($past(nmi_i) && !$past(nmi_prev_q)));
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] STACK_HI = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  evt_kind_e     kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] status_o
);
  localparam logic [DW-1:0] B_MASK = DW'(1) << FLG_B;
  localparam logic [DW-1:0] U_MASK = DW'(1) << FLG_U;
  localparam logic [DW-1:0] I_MASK = DW'(1) << FLG_I;

  seq_state_e    st_q, st_d;
  evt_kind_e     kind_q, kind_d;
  logic [AW-1:0] wpc_q, wpc_d, pc_q;
  logic [DW-1:0] wsp_q, wsp_d, wst_q, wst_d, sp_q, stat_q, fin_st;
  logic          done_q, done_d, work_en, out_en;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    wpc_d   = wpc_q;
    wsp_d   = wsp_q;
    wst_d   = wst_q;
    done_d  = 1'b0;
    work_en = 1'b0;
    out_en  = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        work_en = 1'b1;
        kind_d  = kind_i;
        wpc_d   = pc_i;
        wsp_d   = sp_i;
        wst_d   = status_i & ~B_MASK;
        st_d    = (kind_i == K_RST) ? S_VEC_L : S_FILL0;
      end
      S_FILL0: st_d = S_FILL1;
      S_FILL1: st_d = S_PSH_H;
      S_PSH_H: begin st_d = S_PSH_L; work_en = 1'b1; wsp_d = wsp_q - 1'b1; end
      S_PSH_L: begin st_d = S_PSH_P; work_en = 1'b1; wsp_d = wsp_q - 1'b1; end
      S_PSH_P: begin st_d = S_VEC_L; work_en = 1'b1; wsp_d = wsp_q - 1'b1; end
      S_VEC_L: begin
        st_d = S_VEC_H; work_en = 1'b1;
        wpc_d[DW-1:0] = mem_rdata_i;
      end
      default: begin
        st_d = S_IDLE; work_en = 1'b1; out_en = 1'b1; done_d = 1'b1;
        wpc_d[AW-1:DW] = mem_rdata_i;
      end
    endcase

    case (kind_q)
      K_RST:   fin_st = I_MASK;
      K_IRQ:   fin_st = wst_q | I_MASK;
      default: fin_st = wst_q;
    endcase
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    case (st_q)
      S_PSH_H: begin mem_we_o = 1'b1; mem_addr_o = {STACK_HI, wsp_q}; mem_wdata_o = wpc_q[AW-1:DW]; end
      S_PSH_L: begin mem_we_o = 1'b1; mem_addr_o = {STACK_HI, wsp_q}; mem_wdata_o = wpc_q[DW-1:0]; end
      S_PSH_P: begin mem_we_o = 1'b1; mem_addr_o = {STACK_HI, wsp_q}; mem_wdata_o = wst_q | U_MASK; end
      S_VEC_L: begin mem_re_o = 1'b1; mem_addr_o = vec_base(kind_q); end
      S_VEC_H: begin mem_re_o = 1'b1; mem_addr_o = vec_base(kind_q) | AW'(1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IRQ;
      wpc_q  <= '0;
      wsp_q  <= '0;
      wst_q  <= '0;
    end else if (work_en) begin
      kind_q <= kind_d;
      wpc_q  <= wpc_d;
      wsp_q  <= wsp_d;
      wst_q  <= wst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      sp_q   <= '0;
      stat_q <= '0;
    end else if (out_en) begin
      pc_q   <= wpc_d;
      sp_q   <= wsp_q;
      stat_q <= fin_st;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign sp_o     = sp_q;
  assign status_o = stat_q;

  assert_stack_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_addr_o[AW-1:DW] == STACK_HI);
  assert_push_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && st_q == S_PSH_P) |-> (mem_wdata_o[FLG_U] && !mem_wdata_o[FLG_B]));
  assert_irq_sets_i_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q == K_IRQ) |-> status_o[FLG_I]);
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q != K_RST) |-> ($past(busy_o, 7) && !$past(busy_o, 8) && $past(busy_o, 1)));
  assert_reset_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q == K_RST) |-> (status_o == I_MASK && $past(busy_o, 2) && !$past(busy_o, 3)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          irq_req_i,
  input  logic          nmi_req_i,
  input  logic          rst_req_i,
  input  logic          jam_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] status_o,
  output logic          jammed_o
);
  logic      start;
  evt_kind_e kind;

  irq_evt_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .idle_i       (~busy_o),
    .irq_i        (irq_req_i),
    .nmi_i        (nmi_req_i),
    .rst_req_i    (rst_req_i),
    .jam_i        (jam_i),
    .iflag_now_i  (status_i[FLG_I]),
    .done_i       (done_o),
    .done_iflag_i (status_o[FLG_I]),
    .start_o      (start),
    .kind_o       (kind),
    .jammed_o     (jammed_o)
  );

  irq_entry_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .kind_i      (kind),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .status_i    (status_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .status_o    (status_o)
  );
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0, irq_req_i = 1'b0, nmi_req_i = 1'b0;
  logic        rst_req_i = 1'b0, jam_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  sp_i = '0, status_i = '0;
  logic [7:0]  mem_rdata_i;
  logic [15:0] mem_addr_o, pc_o;
  logic [7:0]  mem_wdata_o, sp_o, status_o;
  logic        mem_we_o, mem_re_o, busy_o, done_o, jammed_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  function automatic logic [7:0] vec_byte(logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h12;
      16'hFFFE: return 8'h78;
      16'hFFFF: return 8'h56;
      16'hFFFC: return 8'hBC;
      16'hFFFD: return 8'h9A;
      default:  return 8'h00;
    endcase
  endfunction
  assign mem_rdata_i = vec_byte(mem_addr_o);

  irq_entry_seq u_irq_entry_seq (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each stack write against the scoreboard queue
  always @(negedge clk) if (rst_n && mem_we_o) begin
    logic [23:0] got, exp;
    got = {mem_addr_o, mem_wdata_o};
    if (exp_q.size() == 0) chk(0, "R4 unexpected write", int'(got), 0);
    else begin
      exp = exp_q.pop_front();
      chk(got == exp, "R4/R5 push addr+data", int'(got), int'(exp));
    end
  end

  task automatic push_exp(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
    exp_q.push_back({8'h01, sp, pc[15:8]});
    exp_q.push_back({8'h01, 8'(sp - 8'd1), pc[7:0]});
    exp_q.push_back({8'h01, 8'(sp - 8'd2), (st & 8'hEF) | 8'h20});
  endtask

  task automatic do_boundary();
    @(negedge clk) boundary_i = 1'b1;
    @(negedge clk) boundary_i = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 40) begin n++; @(negedge clk); end
  endtask

  task automatic entry(input string tag, input logic [15:0] pc, input logic [7:0] sp,
                       input logic [7:0] st, input logic [15:0] epc, input logic [7:0] est);
    int n;
    pc_i = pc; sp_i = sp; status_i = st;
    push_exp(pc, sp, st);
    do_boundary();
    count_busy(n);
    chk(n == 7, {tag, " R7 busy cycles"}, n, 7);
    chk(done_o == 1'b1, {tag, " R7 done pulse"}, done_o, 1);
    chk(pc_o == epc, {tag, " R6 vector pc"}, pc_o, epc);
    chk(sp_o == 8'(sp - 8'd3), {tag, " R4 sp out"}, sp_o, 8'(sp - 8'd3));
    chk(status_o == est, {tag, " R5/R6 status out"}, status_o, est);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R7 done one cycle"}, done_o, 0);
    chk(exp_q.size() == 0, {tag, " R4 all pushes seen"}, exp_q.size(), 0);
  endtask

  task automatic no_entry(input string tag, input logic [7:0] st);
    status_i = st;
    do_boundary();
    chk(busy_o == 1'b0, tag, busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1'b0, tag, busy_o, 0);
  endtask

  task automatic reset_seq(input logic [7:0] sp);
    int n;
    sp_i = sp;
    @(negedge clk) rst_req_i = 1'b1;
    @(negedge clk) rst_req_i = 1'b0;
    count_busy(n);
    chk(n == 2, "R8 reset busy cycles", n, 2);
    chk(done_o == 1'b1, "R8 reset done", done_o, 1);
    chk(pc_o == 16'h9ABC, "R8 reset pc", pc_o, 16'h9ABC);
    chk(status_o == 8'h04, "R8 reset status", status_o, 8'h04);
    chk(sp_o == sp, "R8 reset sp", sp_o, sp);
    chk(jammed_o == 1'b0, "R8 jam cleared", jammed_o, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0 && mem_we_o == 0 && mem_re_o == 0, "R1 idle after reset", busy_o, 0);
    chk(jammed_o == 0 && pc_o == 0 && sp_o == 0 && status_o == 0, "R1 outputs zero", pc_o, 0);

    reset_seq(8'hFD);

    // R3: latch is 1 after reset, so request refused; flag 0 now latched
    irq_req_i = 1'b1;
    no_entry("R3 masked by latched flag", 8'h00);
    // R3: flag set at this boundary but previous was clear -> taken; R5 break cleared
    entry("R3 lagged flag irq", 16'h8000, 8'hFD, 8'h14, 16'h5678, 8'h04);
    // R3: latch now 1 from the entry, flag 0 presented -> refused
    no_entry("R3 refused after entry", 8'h00);

    // R2 both pending, stack wraps (R4), only irq sets I (R6)
    @(negedge clk) nmi_req_i = 1'b1;
    entry("R2 nmi priority", 16'h9001, 8'h01, 8'hC1, 16'h1234, 8'hC1);

    // R10 held nmi level gives no new request: irq is serviced instead
    entry("R10 nmi held irq", 16'h4321, 8'h80, 8'h00, 16'h5678, 8'h04);

    // R10 irq level dropped -> nothing
    irq_req_i = 1'b0;
    no_entry("R10 irq dropped a", 8'h00);
    no_entry("R10 irq dropped b", 8'h00);

    // R10 fresh nmi edge
    @(negedge clk) nmi_req_i = 1'b0;
    @(negedge clk) nmi_req_i = 1'b1;
    entry("R10 new nmi edge", 16'h0200, 8'h10, 8'h30, 16'h1234, 8'h20);

    // R9 jammed: nothing starts, nmi pending dropped
    @(negedge clk) begin jam_i = 1'b1; nmi_req_i = 1'b0; end
    @(negedge clk) begin jam_i = 1'b0; nmi_req_i = 1'b1; irq_req_i = 1'b1; end
    @(negedge clk);
    chk(jammed_o == 1'b1, "R9 jammed set", jammed_o, 1);
    no_entry("R9 jammed blocks", 8'h00);
    irq_req_i = 1'b0;
    reset_seq(8'h55);
    no_entry("R9 nmi dropped while jammed", 8'h00);

    chk(exp_q.size() == 0, "R4 queue empty at end", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule